// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine

This engine copies a block of words from one region of a shared system bus to another without processor involvement. Software loads a source base address, a destination base address, a word count and a control word, then issues a start command. The engine asks for the bus with a request/grant handshake. Each word moves as a bus read from the current source address followed by a bus write of the captured word to the current destination address. Each of the two phases completes on a bus ready input.

The control word picks one of three bus-release policies. In burst mode the engine keeps the bus for the whole block. In single-cycle mode it gives the bus back after every word and asks for it again. In transparent mode it keeps asking, but it starts a word only when the processor signals that it is not using the bus. Each address can step by one word per transfer or stay fixed, which suits a peripheral data register. When the block ends, a sticky done flag is set and, if enabled, an interrupt line is raised. A synchronous abort input stops the engine after the bus phase in progress, and the remaining count stays readable.

Top module: `dma_mover`

## Requirements
- R1: After a start with a nonzero count N, the engine performs N read-then-write word moves in order: the destination memory ends equal to a sequential word-by-word copy, and the count register (offset 2) reads 0 afterwards.
- R2: Offsets 0 (source) and 1 (destination) read back the current addresses. Each advances by one per word written when its enable is set (control bit 0 for source, bit 1 for destination) and stays fixed otherwise.
- R3: After reset, the status word (offset 4: bit 0 busy, bit 1 done), the count, the request and the interrupt are all 0. The control word at offset 3 reads back as written: bit 0 source step, bit 1 destination step, bit 2 interrupt enable, bits 4:3 policy (0 burst, 1 single-cycle, 2 transparent).
- R4: Read and write strobes are asserted only while the grant input is high.
- R5: In burst mode the request stays high from start to the last word, so it falls exactly once per block.
- R6: In single-cycle mode the request falls after every word, so it falls N times for an N-word block.
- R7: In transparent mode a read phase begins only at a clock edge where the bus-idle input was high.
- R8: The count register holds only the low 16 bits of a write, so a block moves at most 65535 words.
- R9: A start with a count of 0 sets done on the next clock, leaves busy low, and never raises the request.
- R10: Done is set when the last word is written and stays set until a command write with bit 1 set clears it. The interrupt output equals done while the interrupt enable is set, and stays low otherwise.
- R11: While busy, writes to offsets 0 through 4 have no effect on addresses, count, control or commands.
- R12: Abort stops the engine after the bus phase in progress. It drops the request, leaves done clear, and leaves the count and the source address at the values for the words not yet written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register offset |
| cfg_wdata | input | ADDR_W | Register write data |
| cfg_rdata | output | ADDR_W | Register read data for cfg_addr (combinational) |
| abort | input | 1 | Synchronous stop request |
| bus_req | output | 1 | Bus request to the processor |
| bus_grant | input | 1 | Bus granted by the processor |
| bus_idle | input | 1 | Processor is not using the bus this cycle |
| bus_oe | output | 1 | Enables the engine's address and strobe drivers |
| bus_addr | output | ADDR_W | Bus address |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data |
| bus_ready | input | 1 | Current bus phase completes at this edge |
| irq | output | 1 | Completion interrupt |

## Verification
The hardest situation to reach from the ports is an abort that lands inside a half-finished word. Depending on where it falls, the engine must either drop the captured read or finish the pending write, and the count must match either way. The bench lets a long burst run until a few writes have completed under random ready delays, then pulses abort. It checks the count and the source address against the number of write handshakes it observed itself. Transparent mode is driven with a rarely asserted idle input and a randomly delayed grant, so that the request is held for many cycles before each read may start.

// File: rtl/dma_mover_pkg.sv
// Package: shared encodings for the block transfer engine.
// Assumes: word-addressed bus, register offsets decoded on 3 bits.
package dma_mover_pkg;

    // Bus-release policy, control bits 4:3
    typedef enum logic [1:0] {
        POL_BURST  = 2'd0,
        POL_SINGLE = 2'd1,
        POL_TRANSP = 2'd2,
        POL_RSVD   = 2'd3
    } policy_e;

    // Sequencer phases
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_REQ  = 3'd1,
        ST_RD   = 3'd2,
        ST_WR   = 3'd3,
        ST_GAP  = 3'd4
    } phase_e;

    // Register offsets
    localparam logic [2:0] RA_SRC  = 3'd0;
    localparam logic [2:0] RA_DST  = 3'd1;
    localparam logic [2:0] RA_CNT  = 3'd2;
    localparam logic [2:0] RA_CTRL = 3'd3;
    localparam logic [2:0] RA_CMD  = 3'd4;

    localparam int CTRL_W = 5;

endpackage

// File: rtl/dma_addr_ctr.sv
// Module: one address pointer. It is loaded by software and steps by one word
// per completed transfer when stepping is enabled.
// Assumes: load and step are never requested in the same cycle (load only when idle).
module dma_addr_ctr #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              step,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] cur
);

    // Pointer register: software load, otherwise optional post-increment
    always_ff @(posedge clk) begin
        if (!rst_n)
            cur <= '0;
        else if (load)
            cur <= load_val;
        else if (step && inc_en)
            cur <= cur + ADDR_W'(1);
    end

endmodule

// File: rtl/dma_cfg.sv
// Module: configuration and status. It holds the word count, the control
// fields and the done flag, and accepts commands only while the engine is idle.
// Assumes: busy comes from the sequencer; word_done and finish are single-cycle pulses.
module dma_cfg
    import dma_mover_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [LEN_W-1:0] wdata,
    input  logic             busy,
    input  logic             word_done,
    input  logic             finish,
    output logic [1:0]       wr_addr,
    output logic [1:0]       inc_en,
    output logic             irq_en,
    output policy_e          pol,
    output logic [LEN_W-1:0] cnt,
    output logic             cnt_last,
    output logic             go,
    output logic             done,
    output logic             irq
);

    logic wr_ok, start_cmd, clr_cmd;

    // Write qualification: software writes count only while idle
    always_comb begin
        wr_ok      = cfg_we && !busy;
        wr_addr[0] = wr_ok && (cfg_addr == RA_SRC);
        wr_addr[1] = wr_ok && (cfg_addr == RA_DST);
        start_cmd  = wr_ok && (cfg_addr == RA_CMD) && wdata[0];
        clr_cmd    = wr_ok && (cfg_addr == RA_CMD) && wdata[1];
        go         = start_cmd && (cnt != '0);
        cnt_last   = (cnt == LEN_W'(1));
        irq        = done && irq_en;
    end

    // Word counter: software load, decrement per written word
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (wr_ok && (cfg_addr == RA_CNT))
            cnt <= wdata;
        else if (word_done)
            cnt <= cnt - LEN_W'(1);
    end

    // Control fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inc_en <= '0;
            irq_en <= 1'b0;
            pol    <= POL_BURST;
        end else if (wr_ok && (cfg_addr == RA_CTRL)) begin
            inc_en <= wdata[1:0];
            irq_en <= wdata[2];
            pol    <= policy_e'(wdata[4:3]);
        end
    end

    // Sticky done flag: zero-count start, completion, software clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            done <= 1'b0;
        else if (start_cmd)
            done <= (cnt == '0);
        else if (clr_cmd)
            done <= 1'b0;
        else if (finish)
            done <= 1'b1;
    end

    // R11
    ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cfg_we) |=> ($stable(pol) && $stable(irq_en) && $stable(inc_en)));

    // R9
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !busy && cfg_addr == RA_CMD && wdata[0] && cnt == '0) |=> (done && !busy));

    // R10
    irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !cfg_we) |=> irq);

endmodule

// File: rtl/dma_seq.sv
// Module: bus sequencer. It handles the request/grant handshake, runs the read
// phase and then the write phase of each word, and applies the release policy and abort.
// Assumes: the grant is held while the request is high once given; the count is nonzero on go.
module dma_seq
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  policy_e           pol,
    input  logic              cnt_last,
    input  logic              abort,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] dst_addr,
    input  logic              bus_grant,
    input  logic              bus_idle,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy,
    output logic              word_done,
    output logic              finish,
    output logic              bus_req,
    output logic              bus_oe,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);

    phase_e            phase;
    logic              abort_pend;
    logic              stop_now;
    logic              may_start;
    logic [DATA_W-1:0] data_q;

    // Decode of the current phase and derived control
    always_comb begin
        busy      = (phase != ST_IDLE);
        bus_req   = (phase == ST_REQ) || (phase == ST_RD) || (phase == ST_WR);
        bus_rd    = (phase == ST_RD);
        bus_wr    = (phase == ST_WR);
        bus_oe    = bus_req && bus_grant;
        word_done = bus_wr && bus_ready;
        finish    = word_done && cnt_last;
        stop_now  = abort || abort_pend;
        may_start = bus_grant && ((pol != POL_TRANSP) || bus_idle);
        bus_wdata = data_q;
        bus_addr  = '0;
        if (phase == ST_RD)
            bus_addr = src_addr;
        else if (phase == ST_WR)
            bus_addr = dst_addr;
    end

    // Phase sequencing per release policy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= ST_IDLE;
        end else begin
            case (phase)
                ST_IDLE: if (go) phase <= ST_REQ;
                ST_REQ: begin
                    if (abort)
                        phase <= ST_IDLE;
                    else if (may_start)
                        phase <= ST_RD;
                end
                ST_RD: if (bus_ready) phase <= stop_now ? ST_IDLE : ST_WR;
                ST_WR: begin
                    if (bus_ready) begin
                        if (cnt_last || stop_now)
                            phase <= ST_IDLE;
                        else if (pol == POL_SINGLE)
                            phase <= ST_GAP;
                        else if (pol == POL_TRANSP)
                            phase <= ST_REQ;
                        else
                            phase <= ST_RD;
                    end
                end
                ST_GAP: phase <= abort ? ST_IDLE : ST_REQ;
                default: phase <= ST_IDLE;
            endcase
        end
    end

    // Abort memory while a bus phase is still waiting for ready
    always_ff @(posedge clk) begin
        if (!rst_n)
            abort_pend <= 1'b0;
        else if (phase == ST_IDLE)
            abort_pend <= 1'b0;
        else if (abort && (bus_rd || bus_wr))
            abort_pend <= 1'b1;
    end

    // Read data capture at the end of the read phase
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (bus_rd && bus_ready)
            data_q <= bus_rdata;
    end

    // R4
    strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |-> bus_grant);

    // R5
    burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready && !cnt_last && !abort && !abort_pend && pol == POL_BURST)
        |=> (bus_rd && bus_req));

    // R6
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_ready && pol == POL_SINGLE) |=> !bus_req);

    // R7
    transp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bus_rd) && pol == POL_TRANSP) |-> $past(bus_idle));

    // R12
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !bus_rd && !bus_wr && busy) |=> !bus_req);

endmodule

// File: rtl/dma_mover.sv
// Module: top of the single-channel block transfer engine. It ties together the
// configuration registers, the two address pointers and the bus sequencer, and
// provides the register read-back mux.
// Assumes: ADDR_W >= LEN_W >= CTRL_W; a word-addressed bus.
module dma_mover
    import dma_mover_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_addr,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output logic [ADDR_W-1:0] cfg_rdata,
    input  logic              abort,
    output logic              bus_req,
    input  logic              bus_grant,
    input  logic              bus_idle,
    output logic              bus_oe,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic              bus_wr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ready,
    output logic              irq
);

    localparam int CNT_PAD  = ADDR_W - LEN_W;
    localparam int CTRL_PAD = ADDR_W - CTRL_W;
    localparam int STAT_PAD = ADDR_W - 2;

    logic [1:0]             wr_addr;
    logic [1:0]             inc_en;
    logic [1:0][ADDR_W-1:0] cur_addr;
    logic                   irq_en, cnt_last, go, done, busy, word_done, finish;
    logic [LEN_W-1:0]       cnt;
    policy_e                pol;

    dma_cfg #(.LEN_W(LEN_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .wdata     (cfg_wdata[LEN_W-1:0]),
        .busy      (busy),
        .word_done (word_done),
        .finish    (finish),
        .wr_addr   (wr_addr),
        .inc_en    (inc_en),
        .irq_en    (irq_en),
        .pol       (pol),
        .cnt       (cnt),
        .cnt_last  (cnt_last),
        .go        (go),
        .done      (done),
        .irq       (irq)
    );

    // Source (index 0) and destination (index 1) pointers
    for (genvar g = 0; g < 2; g++) begin : g_ptr
        dma_addr_ctr #(.ADDR_W(ADDR_W)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (wr_addr[g]),
            .load_val (cfg_wdata),
            .step     (word_done),
            .inc_en   (inc_en[g]),
            .cur      (cur_addr[g])
        );
    end

    dma_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .pol       (pol),
        .cnt_last  (cnt_last),
        .abort     (abort),
        .src_addr  (cur_addr[0]),
        .dst_addr  (cur_addr[1]),
        .bus_grant (bus_grant),
        .bus_idle  (bus_idle),
        .bus_ready (bus_ready),
        .bus_rdata (bus_rdata),
        .busy      (busy),
        .word_done (word_done),
        .finish    (finish),
        .bus_req   (bus_req),
        .bus_oe    (bus_oe),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    // Register read-back mux
    always_comb begin
        case (cfg_addr)
            RA_SRC:  cfg_rdata = cur_addr[0];
            RA_DST:  cfg_rdata = cur_addr[1];
            RA_CNT:  cfg_rdata = {{CNT_PAD{1'b0}}, cnt};
            RA_CTRL: cfg_rdata = {{CTRL_PAD{1'b0}}, pol, irq_en, inc_en};
            RA_CMD:  cfg_rdata = {{STAT_PAD{1'b0}}, done, busy};
            default: cfg_rdata = '0;
        endcase
    end

    // R1
    cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !word_done) |=> $stable(cnt));

    // R2
    src_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !inc_en[0]) |=> $stable(cur_addr[0]));

endmodule

// File: tb/sim_dma_mover.sv
module sim_dma_mover;
    import dma_mover_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        abort = 1'b0;
    logic        bus_req, bus_oe, bus_rd, bus_wr, irq;
    logic        bus_grant, bus_idle, bus_ready;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_mover u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .abort(abort),
        .bus_req(bus_req), .bus_grant(bus_grant), .bus_idle(bus_idle),
        .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
        .irq(irq)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] mem [256];
    logic [31:0] expm [256];
    int pol_cur = 0, idle_pct = 50;
    int req_falls = 0, req_rises = 0, wr_count = 0, viol_grant = 0, viol_idle = 0;
    logic prev_req = 1'b0, prev_rd = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Bus environment: grant, idle, ready, memory; monitors on prior-cycle values
    initial begin
        bus_grant = 1'b0; bus_idle = 1'b0; bus_ready = 1'b0; bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if ((bus_rd || bus_wr) && !bus_grant) viol_grant++;
                if (bus_rd && !prev_rd && pol_cur == 2 && !bus_idle) viol_idle++;
                if (prev_req && !bus_req) req_falls++;
                if (!prev_req && bus_req) req_rises++;
            end
            prev_req  = bus_req;
            prev_rd   = bus_rd;
            bus_grant = bus_req && (bus_grant || ($urandom % 3 == 0));
            bus_idle  = ($urandom % 100) < idle_pct;
            bus_ready = ($urandom % 3) != 0;
            if (bus_rd) bus_rdata = mem[bus_addr[7:0]];
            if (bus_wr && bus_ready) begin
                mem[bus_addr[7:0]] = bus_wdata;
                wr_count++;
            end
        end
    end

    task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic wait_idle(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 20000; i++) begin
            reg_rd(RA_CMD, s);
            if (!s[0]) begin ok = 1; break; end
        end
    endtask

    // One block with expected memory computed as a sequential copy
    task automatic run_block(input logic [31:0] src, input logic [31:0] dst, input int len,
                             input bit si, input bit di, input bit ie, input int pol,
                             input bit poke);
        logic [31:0] s, d, rd, ctrl;
        bit ok;
        int bad;
        for (int i = 0; i < 256; i++) begin
            mem[i] = $urandom;
            expm[i] = mem[i];
        end
        s = src; d = dst;
        for (int i = 0; i < len; i++) begin
            expm[d[7:0]] = expm[s[7:0]];
            if (si) s = s + 1;
            if (di) d = d + 1;
        end
        pol_cur = pol;
        idle_pct = (pol == 2) ? 20 : 50;
        ctrl = {27'd0, 2'(pol), ie, di, si};
        reg_wr(RA_SRC, src);
        reg_wr(RA_DST, dst);
        reg_wr(RA_CNT, 32'(len));
        reg_wr(RA_CTRL, ctrl);
        req_falls = 0; req_rises = 0; wr_count = 0;
        reg_wr(RA_CMD, 32'h1);
        if (poke) begin
            reg_wr(RA_SRC, 32'hABC);
            reg_wr(RA_CTRL, ctrl ^ 32'h1F);
            reg_wr(RA_CNT, 32'd3);
            reg_wr(RA_CMD, 32'h3);
        end
        wait_idle(ok);
        chk(ok, "R1", "block finished", ok, 1);
        bad = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== expm[i]) bad++;
        chk(bad == 0, poke ? "R11" : "R1", "memory mismatches", bad, 0);
        reg_rd(RA_CNT, rd);
        chk(rd == 0, "R1", "count after block", rd, 0);
        reg_rd(RA_SRC, rd);
        chk(rd == s, poke ? "R11" : "R2", "source end address", rd, s);
        reg_rd(RA_DST, rd);
        chk(rd == d, "R2", "destination end address", rd, d);
        if (poke) begin
            reg_rd(RA_CTRL, rd);
            chk(rd == ctrl, "R11", "control unchanged while busy", rd, ctrl);
        end
        reg_rd(RA_CMD, rd);
        chk(rd[1] == 1'b1, "R10", "done after block", rd[1], 1);
        chk(irq == ie, "R10", "irq follows enable", irq, ie);
        if (pol == 1)
            chk(req_falls == len, "R6", "request releases", req_falls, len);
        else
            chk(req_falls == 1, pol == 0 ? "R5" : "R7", "request releases", req_falls, 1);
        reg_wr(RA_CMD, 32'h2);
        reg_rd(RA_CMD, rd);
        chk(rd[1] == 1'b0 && irq == 1'b0, "R10", "done and irq cleared", {rd[1], irq}, 0);
    endtask

    initial begin
        logic [31:0] rd;
        bit ok;
        int exp_cnt;
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R3 reset state and control field layout
        reg_rd(RA_CMD, rd);
        chk(rd == 0, "R3", "status after reset", rd, 0);
        reg_rd(RA_CNT, rd);
        chk(rd == 0, "R3", "count after reset", rd, 0);
        chk(bus_req == 0 && irq == 0, "R3", "req/irq after reset", {bus_req, irq}, 0);
        reg_wr(RA_CTRL, 32'h15);
        reg_rd(RA_CTRL, rd);
        chk(rd == 32'h15, "R3", "control readback", rd, 32'h15);

        // R8 count width
        reg_wr(RA_CNT, 32'h0001_2345);
        reg_rd(RA_CNT, rd);
        chk(rd == 32'h2345, "R8", "count truncated to 16 bits", rd, 32'h2345);

        // R9 zero count
        reg_wr(RA_CNT, 32'h0);
        req_rises = 0;
        reg_wr(RA_CMD, 32'h1);
        reg_rd(RA_CMD, rd);
        chk(rd[1:0] == 2'b10, "R9", "zero count: done, not busy", rd[1:0], 2);
        repeat (10) @(negedge clk);
        chk(req_rises == 0, "R9", "zero count never requests", req_rises, 0);
        reg_wr(RA_CMD, 32'h2);

        // Directed blocks
        run_block(32'd5,   32'd100, 8,  1, 1, 1, 0, 0);   // burst, both step, R5
        run_block(32'd30,  32'd200, 6,  1, 1, 0, 1, 0);   // single, R6
        run_block(32'd50,  32'd150, 7,  1, 1, 1, 2, 0);   // transparent, R7
        run_block(32'd77,  32'd10,  5,  0, 1, 0, 0, 0);   // fixed source, R2
        run_block(32'd40,  32'd90,  9,  1, 0, 1, 1, 0);   // fixed destination, R2
        run_block(32'd250, 32'd120, 1,  1, 1, 0, 2, 0);   // single word
        run_block(32'd10,  32'd60,  12, 1, 1, 0, 1, 1);   // R11 writes while busy

        // Random blocks
        for (int k = 0; k < 10; k++)
            run_block($urandom % 256, $urandom % 256, 1 + int'($urandom % 24),
                      1'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 3), 0);

        // R12 abort in the middle of a burst
        pol_cur = 0; idle_pct = 50;
        reg_wr(RA_SRC, 32'd0);
        reg_wr(RA_DST, 32'd100);
        reg_wr(RA_CNT, 32'd40);
        reg_wr(RA_CTRL, 32'h3);
        wr_count = 0;
        reg_wr(RA_CMD, 32'h1);
        while (wr_count < 5) @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        wait_idle(ok);
        chk(ok, "R12", "abort ends block", ok, 1);
        chk(bus_req == 0, "R12", "request dropped", bus_req, 0);
        exp_cnt = 40 - wr_count;
        reg_rd(RA_CNT, rd);
        chk(rd == 32'(exp_cnt), "R12", "remaining count", rd, exp_cnt);
        reg_rd(RA_SRC, rd);
        chk(rd == 32'(wr_count), "R12", "source at next word", rd, wr_count);
        reg_rd(RA_CMD, rd);
        chk(rd[1] == 1'b0, "R12", "done stays clear", rd[1], 0);

        chk(viol_grant == 0, "R4", "strobes without grant", viol_grant, 0);
        chk(viol_idle == 0, "R7", "reads started without idle", viol_idle, 0);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not finish actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule